// File: doc/BRIEF.md
# Converter Result Holding Registers

This block keeps the most recent result of a data converter and presents it to a processor as two byte-wide registers, one holding the lower part of the word and one holding the upper part. A conversion engine, modelled here only as a completion pulse with a 10-bit value, hands results to the block. An alignment control chooses how the result sits in the 16-bit word: packed toward the least significant end or toward the most significant end. Bit positions that carry no result read as zero.

Software reads the two bytes through a single read strobe and a one-bit byte select. The data output is combinational and shows the selected byte during the read cycle. Reading the lower byte freezes both registers, so a later read of the upper byte returns a byte from the same conversion. Reading the upper byte lifts the freeze. A conversion that finishes while the registers are frozen is dropped. Its completion flag is still raised, so software learns that a result arrived. The flag stays set until software clears it by writing a one.

Top module: `cnv_result_regs`

## Requirements
- R1: After reset both bytes read as 0x00, the completion flag is 0 and the registers are not frozen.
- R2: With align_left_i = 0, byte select 0 returns result[7:0] and byte select 1 returns {6'b0, result[9:8]}.
- R3: With align_left_i = 1, byte select 1 returns result[9:2] and byte select 0 returns {result[1:0], 6'b0}.
- R4: A read with byte select 0 freezes the registers. A completion in the same cycle as that read, or in any later cycle while the freeze holds, leaves the stored result unchanged.
- R5: A read with byte select 1 releases the freeze from the following cycle. A completion in the same cycle as that read is still dropped.
- R6: Every completion pulse sets the flag on the next cycle, whether its result was stored or dropped.
- R7: A read with byte select 1 while the registers are not frozen leaves them not frozen, so the next completion is stored.
- R8: A change of align_left_i re-maps the stored result on the very next read, with no new conversion.
- R9: A one on flag_clr_i clears the flag on the next cycle. If a completion arrives in the same cycle as the clear, the flag stays set.
- R10: A completion that is accepted is readable from the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle completion pulse from the conversion engine |
| conv_value_i | input | 10 | Result that accompanies the completion pulse |
| align_left_i | input | 1 | 1 selects packing toward the most significant end |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Byte select: 0 selects the lower byte, 1 selects the upper byte |
| rd_data_o | output | 8 | Selected byte, valid while rd_en_i is high |
| flag_clr_i | input | 1 | A one clears the completion flag |
| done_flag_o | output | 1 | Completion flag |

## Verification
The assertions assume that a completion pulse lasts one cycle and that conv_value_i is valid only while the pulse is high. They also assume that each read strobe selects exactly one byte, and that a freeze and a release can never be requested in the same cycle. The stimulus respects all of this. Every input changes on the falling clock edge, pulses are driven for exactly one cycle, and the bench sends a single strobe per read. Deliberately colliding events (a completion together with a lower-byte read, with an upper-byte read, or with a flag clear) are still legal inputs, so the properties are written to accept them.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;

endpackage

// File: rtl/cnv_freeze_ctrl.sv
module cnv_freeze_ctrl
  import cnv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en_i,
  input  logic rd_sel_i,
  input  logic conv_done_i,
  output logic frozen_o,
  output logic store_en_o
);

  logic freeze_q;
  logic freeze_d;
  logic rd_low;
  logic rd_high;

  assign rd_low  = rd_en_i && (rd_sel_i == SEL_LOW);
  assign rd_high = rd_en_i && (rd_sel_i == SEL_HIGH);

  always_comb begin
    freeze_d = freeze_q;
    if (rd_low) begin
      freeze_d = 1'b1;
    end else if (rd_high) begin
      freeze_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
    end else begin
      freeze_q <= freeze_d;
    end
  end

  // A lower-byte read in this cycle already blocks the store, so the pair stays coherent.
  assign store_en_o = conv_done_i && !freeze_q && !rd_low;
  assign frozen_o   = freeze_q;

  p_low_read_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_low |=> frozen_o);

  p_high_read_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_high |=> !frozen_o);

  p_unfrozen_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_o && !rd_low) |=> !frozen_o);

endmodule

// File: rtl/cnv_result_store.sv
module cnv_result_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en_i,
  input  logic [RES_W-1:0] value_i,
  output logic [RES_W-1:0] result_o
);

  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;

  always_comb begin
    res_d = res_q;
    if (store_en_i) begin
      res_d = value_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign result_o = res_q;

  p_hold_when_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !store_en_i |=> $stable(result_o));

  p_accept_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    store_en_i |=> (result_o == $past(value_i)));

endmodule

// File: rtl/cnv_done_flag.sv
module cnv_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // A completion wins over a clear that arrives in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (conv_done_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i |=> flag_o);

  p_clear_drops_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !conv_done_i) |=> !flag_o);

  p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !conv_done_i) |=> $stable(flag_o));

endmodule

// File: rtl/cnv_byte_map.sv
module cnv_byte_map
  import cnv_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  result_i,
  input  logic              align_left_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word_right;
  logic [WORD_W-1:0] word_left;
  logic [WORD_W-1:0] word_sel;

  generate
    if (PAD_W > 0) begin : g_padded
      assign word_right = {{PAD_W{1'b0}}, result_i};
      assign word_left  = {result_i, {PAD_W{1'b0}}};
    end else begin : g_full
      assign word_right = result_i;
      assign word_left  = result_i;
    end
  endgenerate

  always_comb begin
    word_sel = align_left_i ? word_left : word_right;
    if (rd_sel_i == SEL_HIGH) begin
      byte_o = word_sel[WORD_W-1:BYTE_W];
    end else begin
      byte_o = word_sel[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/cnv_result_regs.sv
module cnv_result_regs #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_value_i,
  input  logic              align_left_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              flag_clr_i,
  output logic              done_flag_o
);

  logic             frozen;
  logic             store_en;
  logic [RES_W-1:0] result;

  cnv_freeze_ctrl u_freeze (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (rd_en_i),
    .rd_sel_i    (rd_sel_i),
    .conv_done_i (conv_done_i),
    .frozen_o    (frozen),
    .store_en_o  (store_en)
  );

  cnv_result_store #(.RES_W(RES_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_en_i (store_en),
    .value_i    (conv_value_i),
    .result_o   (result)
  );

  cnv_done_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done_i (conv_done_i),
    .clr_i       (flag_clr_i),
    .flag_o      (done_flag_o)
  );

  cnv_byte_map #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_map (
    .result_i     (result),
    .align_left_i (align_left_i),
    .rd_sel_i     (rd_sel_i),
    .byte_o       (rd_data_o)
  );

  p_frozen_drops_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && conv_done_i) |=> $stable(result));

endmodule

// File: tb/test_cnv_result_regs.sv
module test_cnv_result_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  // {value[9:0], align_left, expected low byte, expected high byte}
  localparam logic [26:0] VECS [NVEC] = '{
    {10'h3FF, 1'b0, 8'hFF, 8'h03},
    {10'h155, 1'b1, 8'h40, 8'h55},
    {10'h2A3, 1'b0, 8'hA3, 8'h02},
    {10'h2A3, 1'b1, 8'hC0, 8'hA8},
    {10'h001, 1'b1, 8'h40, 8'h00},
    {10'h200, 1'b0, 8'h00, 8'h02},
    {10'h0F0, 1'b1, 8'h00, 8'h3C}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_done_i;
  logic [9:0] conv_value_i;
  logic       align_left_i;
  logic       rd_en_i;
  logic       rd_sel_i;
  logic [7:0] rd_data_o;
  logic       flag_clr_i;
  logic       done_flag_o;

  int errors = 0;
  int checks = 0;

  cnv_result_regs i_cnv_result_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done_i  (conv_done_i),
    .conv_value_i (conv_value_i),
    .align_left_i (align_left_i),
    .rd_en_i      (rd_en_i),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o),
    .flag_clr_i   (flag_clr_i),
    .done_flag_o  (done_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, starting and ending at a falling edge. The read data is sampled before the rising edge.
  task automatic step(input logic rd, input logic sel, input logic done, input logic [9:0] val,
                      input logic clr, output logic [7:0] data);
    rd_en_i = rd;
    rd_sel_i = sel;
    conv_done_i = done;
    conv_value_i = val;
    flag_clr_i = clr;
    #1;
    data = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
    conv_done_i = 1'b0;
    conv_value_i = '0;
    flag_clr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0;
    conv_done_i = 1'b0;
    conv_value_i = '0;
    align_left_i = 1'b0;
    rd_en_i = 1'b0;
    rd_sel_i = 1'b0;
    flag_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flag", {7'b0, done_flag_o}, 8'h00);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R1 low", d, 8'h00);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R1 high", d, 8'h00);

    // Vector walk: R2 / R3 / R10
    for (int i = 0; i < NVEC; i++) begin
      align_left_i = VECS[i][16];
      step(1'b0, 1'b0, 1'b1, VECS[i][26:17], 1'b0, d);
      step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d);
      check(VECS[i][16] ? "R3 low" : "R2 low", d, VECS[i][15:8]);
      step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d);
      check(VECS[i][16] ? "R3 high" : "R2 high", d, VECS[i][7:0]);
    end

    // R10 readable the cycle right after the pulse
    align_left_i = 1'b0;
    step(1'b0, 1'b0, 1'b1, 10'h155, 1'b0, d);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R10 next cycle", d, 8'h55);

    // R4 frozen: completion dropped, but R6 the flag is still raised
    step(1'b0, 1'b0, 1'b0, 10'h0, 1'b1, d);
    check("R9 clear", {7'b0, done_flag_o}, 8'h00);
    step(1'b0, 1'b0, 1'b1, 10'h3FF, 1'b0, d);
    check("R6 flag on dropped", {7'b0, done_flag_o}, 8'h01);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R4 low held", d, 8'h55);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R4 high held", d, 8'h01);

    // R5 after release the next completion is stored
    step(1'b0, 1'b0, 1'b1, 10'h3FF, 1'b0, d);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R5 low after release", d, 8'hFF);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R5 high after release", d, 8'h03);

    // R4 completion in the same cycle as the lower-byte read is dropped
    step(1'b1, 1'b0, 1'b1, 10'h001, 1'b0, d); check("R4 same-cycle low", d, 8'hFF);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R4 same-cycle high", d, 8'h03);

    // R5 completion in the same cycle as the releasing read is dropped
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d);
    step(1'b1, 1'b1, 1'b1, 10'h002, 1'b0, d); check("R5 same-cycle high", d, 8'h03);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R5 dropped low", d, 8'hFF);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d);

    // R7 upper-byte read alone keeps the registers open
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R7 high only", d, 8'h03);
    step(1'b0, 1'b0, 1'b1, 10'h0F0, 1'b0, d);
    step(1'b1, 1'b0, 1'b0, 10'h0, 1'b0, d); check("R7 stored", d, 8'hF0);
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d);

    // R8 alignment change re-maps without a new conversion
    align_left_i = 1'b1;
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R8 left high", d, 8'h3C);
    align_left_i = 1'b0;
    step(1'b1, 1'b1, 1'b0, 10'h0, 1'b0, d); check("R8 right high", d, 8'h00);

    // R9 clear priority and clear behaviour
    step(1'b0, 1'b0, 1'b1, 10'h0F0, 1'b1, d);
    check("R9 done beats clear", {7'b0, done_flag_o}, 8'h01);
    step(1'b0, 1'b0, 1'b0, 10'h0, 1'b1, d);
    check("R9 clear alone", {7'b0, done_flag_o}, 8'h00);
    step(1'b0, 1'b0, 1'b0, 10'h0, 1'b0, d);
    check("R9 stays clear", {7'b0, done_flag_o}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule